// File: doc/BRIEF.md
# Token-Authenticated Serial Command Receiver

This block listens on a slow two-wire link (a serial clock line and a serial data line) driven by an external host. It takes one data bit on every falling edge of the serial clock and only accepts a command after a fixed 16-bit authentication token has arrived intact, least significant bit first. After the token, a 4-bit command code is gathered, also least significant bit first. The code is then decoded into one of two single-cycle request pulses for a downstream sequencer. One pulse starts an erase and reset sequence. The other re-enables the UART pads.

Both lines are brought into the system clock domain through synchronizers. A millisecond tick drives a saturating gap counter. If the gap between two falling edges is too long, the frame is abandoned and a new token is required. A lock input from the sequencer blocks a new erase request while a sequence is still running. A code that would request an erase while the lock is set is dropped without any pulse.

Top module: `auth_cmd_rx`

## Requirements
- R1: While reset is asserted and after its release, both request outputs are low, and the bit position starts at 0.
- R2: Exactly one data bit is taken for each falling edge of the serial clock line. Rising edges and a steady line take no bit.
- R3: At bit position n (0 to 15) the received bit must equal bit n of the token 16'h5A5A. A match advances the position. A mismatch returns the position to 0, and the mismatching bit is discarded.
- R4: After 16 matched token bits, the next 4 bits form the command code. The first of them is code bit 0.
- R5: A code of 4'hF received while the lock input is low produces a one-cycle pulse on `erase_req`. The pulse comes in the cycle after the system clock cycle that takes the 20th bit.
- R6: A code of 4'hF received while the lock input is high produces no pulse on either output.
- R7: Any code other than 4'hF produces a one-cycle pulse on `uart_on_req`, whatever the lock input is.
- R8: If more than TIMEOUT_MS millisecond ticks arrive between two taken bits, the position and the partial code are cleared before the new bit is handled. A gap of exactly TIMEOUT_MS ticks is still accepted.
- R9: After the 20th bit, the position and the code return to 0. The next command needs a complete token again.
- R10: The two request outputs are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| ser_clk | input | 1 | Raw serial clock line; a bit is taken on its falling edge |
| ser_dat | input | 1 | Raw serial data line |
| seq_lock | input | 1 | High while the sequencer is busy; blocks erase requests |
| erase_req | output | 1 | One-cycle request to start the erase/reset sequence |
| uart_on_req | output | 1 | One-cycle request to re-enable the UART pads |

## Verification
The bench builds the receiver with the default token, the default code width and 2 synchronizer stages, but with TIMEOUT_MS set to 6. Each millisecond tick is generated by the bench itself. With this small limit, gaps just at and just beyond the timeout can be placed at any bit position of a frame within a few dozen cycles. These include the boundary between 6 and 7 ticks during both the token and the code phase. Random frames combine corrupted token bits, random codes, random lock values and random slow gaps.

// File: rtl/auth_rx_pkg.sv
package auth_rx_pkg;
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_ERASE = 2'd1,
    REQ_UART  = 2'd2
  } req_e;
endpackage

// File: rtl/line_sync_fall.sv
// Synchronizes the serial clock and data lines and flags each falling
// edge of the serial clock in the system clock domain.
module line_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_clk,
  input  logic line_dat,
  output logic fall,
  output logic dat_s
);
  logic [STAGES-1:0] clk_sr_q, clk_sr_d;
  logic [STAGES-1:0] dat_sr_q, dat_sr_d;
  logic              clk_prev_q;

  always_comb begin
    clk_sr_d = {clk_sr_q[STAGES-2:0], line_clk};
    dat_sr_d = {dat_sr_q[STAGES-2:0], line_dat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sr_q   <= '1;
      dat_sr_q   <= '0;
      clk_prev_q <= 1'b1;
    end else begin
      clk_sr_q   <= clk_sr_d;
      dat_sr_q   <= dat_sr_d;
      clk_prev_q <= clk_sr_q[STAGES-1];
    end
  end

  assign fall  = clk_prev_q & ~clk_sr_q[STAGES-1];
  assign dat_s = dat_sr_q[STAGES-1];
endmodule

// File: rtl/gap_timer.sv
// Saturating millisecond counter, cleared on each taken bit.
module gap_timer #(
  parameter int LIMIT = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic over
);
  localparam int W = $clog2(LIMIT + 2);
  localparam logic [W-1:0] SAT = W'(LIMIT + 1);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clear | (tick & (cnt_q != SAT));
    cnt_d  = clear ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign over = (cnt_q == SAT);
endmodule

// File: rtl/frame_decoder.sv
// Token gate, command assembly and decode into registered request pulses.
module frame_decoder
  import auth_rx_pkg::*;
#(
  parameter int              TOKEN_W    = 16,
  parameter logic [TOKEN_W-1:0] TOKEN   = 16'h5A5A,
  parameter int              CODE_W     = 4,
  parameter logic [CODE_W-1:0] ERASE_CODE = 4'hF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_val,
  input  logic timed_out,
  input  logic lock,
  output logic erase_req,
  output logic uart_req
);
  localparam int FRAME_W = TOKEN_W + CODE_W;
  localparam int POS_W   = $clog2(FRAME_W + 1);
  localparam int TIDX_W  = $clog2(TOKEN_W);
  localparam int CIDX_W  = $clog2(CODE_W);
  localparam logic [POS_W-1:0] TOK_END   = POS_W'(TOKEN_W);
  localparam logic [POS_W-1:0] FRAME_END = POS_W'(FRAME_W);
  localparam logic [POS_W-1:0] ONE       = POS_W'(1);

  logic [POS_W-1:0]  pos_q, pos_d, pos_eff, code_off;
  logic [CODE_W-1:0] code_q, code_d;
  req_e              req_d;
  logic              erase_q, uart_q;

  always_comb begin
    pos_eff  = timed_out ? '0 : pos_q;
    code_off = pos_eff - TOK_END;
    pos_d    = pos_q;
    code_d   = code_q;
    req_d    = REQ_NONE;
    if (bit_en) begin
      if (pos_eff < TOK_END) begin
        code_d = '0;
        if (bit_val == TOKEN[pos_eff[TIDX_W-1:0]]) pos_d = pos_eff + ONE;
        else                                        pos_d = '0;
      end else begin
        code_d[code_off[CIDX_W-1:0]] = bit_val;
        pos_d = pos_eff + ONE;
        if (pos_d == FRAME_END) begin
          if (code_d != ERASE_CODE) req_d = REQ_UART;
          else if (!lock)           req_d = REQ_ERASE;
          pos_d  = '0;
          code_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      code_q  <= '0;
      erase_q <= 1'b0;
      uart_q  <= 1'b0;
    end else begin
      if (bit_en) begin
        pos_q  <= pos_d;
        code_q <= code_d;
      end
      erase_q <= (req_d == REQ_ERASE);
      uart_q  <= (req_d == REQ_UART);
    end
  end

  assign erase_req = erase_q;
  assign uart_req  = uart_q;
endmodule

// File: rtl/auth_cmd_rx.sv
module auth_cmd_rx #(
  parameter int               SYNC_STAGES = 2,
  parameter int               TOKEN_W     = 16,
  parameter logic [TOKEN_W-1:0] TOKEN     = 16'h5A5A,
  parameter int               CODE_W      = 4,
  parameter logic [CODE_W-1:0]  ERASE_CODE = 4'hF,
  parameter int               TIMEOUT_MS  = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic ser_clk,
  input  logic ser_dat,
  input  logic seq_lock,
  output logic erase_req,
  output logic uart_on_req
);
  logic fall, dat_s, over;

  line_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_clk(ser_clk), .line_dat(ser_dat),
    .fall(fall), .dat_s(dat_s)
  );

  gap_timer #(.LIMIT(TIMEOUT_MS)) u_gap (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .clear(fall), .over(over)
  );

  frame_decoder #(
    .TOKEN_W(TOKEN_W), .TOKEN(TOKEN), .CODE_W(CODE_W), .ERASE_CODE(ERASE_CODE)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .bit_en(fall), .bit_val(dat_s),
    .timed_out(over), .lock(seq_lock),
    .erase_req(erase_req), .uart_req(uart_on_req)
  );
endmodule

// File: rtl/auth_cmd_rx_chk.sv
module auth_cmd_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic seq_lock,
  input logic erase_req,
  input logic uart_on_req
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_idle_in_reset_r1: assert (!erase_req && !uart_on_req);
    end
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_req && uart_on_req));

  p_erase_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);

  p_uart_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uart_on_req |=> !uart_on_req);

  p_erase_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_req) |-> !$past(seq_lock));
endmodule

bind auth_cmd_rx auth_cmd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .seq_lock(seq_lock),
  .erase_req(erase_req), .uart_on_req(uart_on_req)
);

// File: tb/tb_auth_cmd_rx.sv
module tb_auth_cmd_rx;
  localparam int LIM = 6;
  localparam logic [15:0] TOK = 16'h5A5A;

  logic clk, rst_n, ms_tick, ser_clk, ser_dat, seq_lock;
  logic erase_req, uart_on_req;
  int total, bad, n_erase, n_uart, e_erase, e_uart, m_pos, cyc;
  logic [3:0] m_code;
  bit done;

  auth_cmd_rx #(.TIMEOUT_MS(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .seq_lock(seq_lock),
    .erase_req(erase_req), .uart_on_req(uart_on_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && erase_req) n_erase <= n_erase + 1;
    if (rst_n && uart_on_req) n_uart <= n_uart + 1;
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model, one taken bit
  task automatic m_bit(bit b, int ticks);
    if (ticks > LIM) m_pos = 0;
    if (m_pos < 16) begin
      m_code = 4'h0;
      m_pos = (b == TOK[m_pos]) ? m_pos + 1 : 0;
    end else begin
      m_code[m_pos-16] = b;
      m_pos++;
      if (m_pos == 20) begin
        if (m_code != 4'hF) e_uart++;
        else if (!seq_lock) e_erase++;
        m_pos = 0;
        m_code = 4'h0;
      end
    end
  endtask

  task automatic send_bit(bit b, int ticks);
    ser_dat = b;
    repeat (4) @(negedge clk);
    for (int i = 0; i < ticks; i++) begin
      ms_tick = 1'b1; @(negedge clk);
      ms_tick = 1'b0; @(negedge clk);
    end
    ser_clk = 1'b0;
    m_bit(b, ticks);
    repeat (6) @(negedge clk);
    ser_clk = 1'b1;
  endtask

  task automatic send_frame(logic [15:0] tok, logic [3:0] code, int ticks,
                            int slow_pos, int slow_ticks);
    logic [19:0] f;
    f = {code, tok};
    for (int i = 0; i < 20; i++)
      send_bit(f[i], (i == slow_pos) ? slow_ticks : ticks);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_counts(string req);
    chk({req, " erase"}, n_erase, e_erase);
    chk({req, " uart"}, n_uart, e_uart);
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(negedge clk);
      if (cyc > 150000 && !done) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    logic [15:0] t;
    logic [3:0] cd;
    int sp, st;
    total = 0; bad = 0; n_erase = 0; n_uart = 0; e_erase = 0; e_uart = 0;
    m_pos = 0; m_code = 4'h0; done = 0;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; ms_tick = 1'b0; ser_clk = 1'b1; ser_dat = 1'b0; seq_lock = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 erase in reset", int'(erase_req), 0);
    chk("R1 uart in reset", int'(uart_on_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 erase after reset", int'(erase_req), 0);
    chk("R1 uart after reset", int'(uart_on_req), 0);

    // R5 erase with lock clear; R3 R4 token and code order
    send_frame(TOK, 4'hF, 1, -1, 0);
    chk_counts("R5");
    // R6 erase dropped while locked
    seq_lock = 1'b1;
    send_frame(TOK, 4'hF, 0, -1, 0);
    chk_counts("R6");
    // R7 other codes, lock does not matter
    send_frame(TOK, 4'h7, 0, -1, 0);
    chk_counts("R7 code 7 locked");
    seq_lock = 1'b0;
    send_frame(TOK, 4'h0, 0, -1, 0);
    chk_counts("R7 code 0");
    // R4 code bit order: 4'hE differs from 4'hF only in first code bit
    send_frame(TOK, 4'hE, 0, -1, 0);
    chk_counts("R4 code E");
    // R3 corrupted token bit, then R9 a fresh frame needs a full token
    send_frame(TOK ^ 16'h0100, 4'hF, 0, -1, 0);
    chk_counts("R3 bad token");
    send_frame(TOK, 4'hF, 0, -1, 0);
    chk_counts("R9 fresh frame");
    // R8 gap exactly at limit accepted, one beyond restarts
    send_frame(TOK, 4'hF, 0, 10, LIM);
    chk_counts("R8 gap at limit");
    send_frame(TOK, 4'hF, 0, 10, LIM + 1);
    chk_counts("R8 gap over limit in token");
    send_frame(TOK, 4'h3, 0, 18, LIM + 1);
    chk_counts("R8 gap over limit in code");
    // R2 rising edge alone takes no bit: a lone rise/fall pair of half frame
    for (int i = 0; i < 16; i++) send_bit(TOK[i], 0);
    ser_dat = 1'b1; repeat (10) @(negedge clk);
    chk("R2 model pos", m_pos, 16);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 0);
    repeat (3) @(negedge clk);
    chk_counts("R2 split frame");

    for (int k = 0; k < 60; k++) begin
      t = TOK;
      if ($urandom % 4 == 0) t = t ^ (16'h1 << ($urandom % 16));
      cd = 4'($urandom);
      if ($urandom % 2 == 0) cd = 4'hF;
      seq_lock = 1'($urandom);
      sp = $urandom % 20;
      st = $urandom % 9;
      send_frame(t, cd, $urandom % 3, sp, st);
      chk_counts("R3 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule